// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This block takes a stream of 64-bit samples and writes them to a circular buffer in external memory. Samples go into an internal FIFO. Whenever the FIFO holds one full burst, the block sends that burst over a memory-mapped write master. Each burst is a fixed-length incrementing transfer of 16 beats.

The ring buffer starts at a base address and holds a run-time number of bursts. A burst counter chooses the slot for each burst. The counter advances once the write response for a burst has been accepted. It returns to zero after the slot whose index equals the configured wrap value. The counter is always visible on a status output, so software can tell how far the buffer has been filled. Both the base address and the wrap value may be changed while the block is running. Each burst uses the values present when that burst is issued.

Top module: `stream_burst_writer`

## Requirements
- R1: The write address channel is not raised unless the FIFO held at least 16 samples in the cycle the burst was launched. With fewer than 16 samples buffered, no burst is ever started.
- R2: Each burst moves exactly 16 FIFO entries, oldest first. `m_wlast` is high on the 16th beat only, and `m_wstrb` is all ones on every beat.
- R3: Every address beat carries length code 15, size code 3 (8 bytes per beat) and burst type code 2'b01 (incrementing).
- R4: After each accepted write response, `burst_cnt` becomes 0 if it equalled `wrap_bursts`, and otherwise increments by 1 modulo 2^CNT_W. At all other times `burst_cnt` holds its value.
- R5: A burst's address is `base_addr + burst_cnt * 128`, truncated to the address width, using the values present when the burst is launched.
- R6: A new address beat is never issued while an earlier burst still awaits its write response. Data beats are issued only after their address beat has been accepted.
- R7: `s_tready` is low exactly when the FIFO holds its full depth of entries.
- R8: A synchronous active-low reset clears the burst counter and empties the FIFO, so buffered samples are discarded. The valid outputs drop and `s_tready` goes high.
- R9: While `m_awvalid` is high and `m_awready` is low, `m_awvalid` stays high and `m_awaddr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Byte address of the first ring slot |
| wrap_bursts | input | CNT_W | Index of the last ring slot before the counter returns to 0 |
| burst_cnt | output | CNT_W | Current burst counter |
| s_tdata | input | DATA_W | Stream sample |
| s_tvalid | input | 1 | Stream sample valid |
| s_tready | output | 1 | Stream ready (FIFO not full) |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Burst length code (beats minus one) |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type code |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of a burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The bench builds the block with a 32-entry FIFO (FIFO_AW = 5), which holds two bursts. A short address-channel stall is therefore enough to fill the FIFO and drop `s_tready`. The burst counter is built 4 bits wide (CNT_W = 4), so the counter can climb past a newly lowered wrap value, roll over through 15 and come back to 0. The data width, address width and burst length stay at their defaults. This keeps the 128-byte slot spacing and the fixed transfer codes under test.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    // Write-side sequencing: launch address, stream data, collect response.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_ADDR = 2'd1,
        WS_DATA = 2'd2,
        WS_RESP = 2'd3
    } wr_state_e;

    localparam logic [1:0] AXI_BURST_INCR = 2'b01;

endpackage

// File: rtl/sbw_fifo.sv
module sbw_fifo #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [ADDR_W:0]   level,
    output logic              full,
    output logic              empty
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = st_q.wr + 1'b1;
        if (pop)  st_d.rd = st_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr] <= din;
    end

    assign dout  = mem[st_q.rd];
    assign level = st_q.cnt;
    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (level == FULL_CNT) || (level == FULL_CNT - 1'b1));  // R7

endmodule

// File: rtl/sbw_ring_addr.sv
module sbw_ring_addr #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int OFFS_LG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  wrap_bursts,
    input  logic              advance,
    output logic [CNT_W-1:0]  burst_cnt,
    output logic [ADDR_W-1:0] burst_addr
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            if (cnt_q == wrap_bursts) cnt_d = '0;
            else                      cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Slot offset is a shift: each slot spans 2^OFFS_LG bytes.
    assign burst_addr = base_addr + (ADDR_W'(cnt_q) << OFFS_LG);
    assign burst_cnt  = cnt_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        advance && (cnt_q == wrap_bursts) |=> (cnt_q == '0));  // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cnt_q));  // R4

endmodule

// File: rtl/stream_burst_writer.sv
module stream_burst_writer
    import sbw_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int FIFO_AW = 5,
    parameter int BEATS   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [CNT_W-1:0]      wrap_bursts,
    output logic [CNT_W-1:0]      burst_cnt,
    input  logic [DATA_W-1:0]     s_tdata,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [7:0]            m_awlen,
    output logic [2:0]            m_awsize,
    output logic [1:0]            m_awburst,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    output logic                  m_wlast,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic                  m_bvalid,
    output logic                  m_bready
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int SIZE_LG    = $clog2(BEAT_BYTES);
    localparam int BURST_LG   = $clog2(BEATS * BEAT_BYTES);
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int FIFO_DEPTH = 1 << FIFO_AW;
    localparam logic [BEAT_W-1:0]  LAST_BEAT  = BEAT_W'(BEATS - 1);
    localparam logic [FIFO_AW:0]   BURST_FILL = (FIFO_AW+1)'(BEATS);
    localparam logic [FIFO_AW:0]   DEPTH_C    = (FIFO_AW+1)'(FIFO_DEPTH);

    typedef struct packed {
        wr_state_e         st;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] awaddr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [FIFO_AW:0]  fifo_level;
    logic [DATA_W-1:0] fifo_dout;
    logic              ring_adv;
    logic [ADDR_W-1:0] ring_addr;

    assign s_tready  = !fifo_full;
    assign fifo_push = s_tvalid && !fifo_full;

    sbw_fifo #(
        .DATA_W (DATA_W),
        .ADDR_W (FIFO_AW)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (s_tdata),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sbw_ring_addr #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .OFFS_LG (BURST_LG)
    ) i_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_addr   (base_addr),
        .wrap_bursts (wrap_bursts),
        .advance     (ring_adv),
        .burst_cnt   (burst_cnt),
        .burst_addr  (ring_addr)
    );

    always_comb begin
        ctl_d    = ctl_q;
        fifo_pop = 1'b0;
        ring_adv = 1'b0;
        case (ctl_q.st)
            WS_IDLE: begin
                if (fifo_level >= BURST_FILL) begin
                    ctl_d.st     = WS_ADDR;
                    ctl_d.awaddr = ring_addr;
                end
            end
            WS_ADDR: begin
                if (m_awready) begin
                    ctl_d.st   = WS_DATA;
                    ctl_d.beat = '0;
                end
            end
            WS_DATA: begin
                if (m_wready) begin
                    fifo_pop   = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) ctl_d.st = WS_RESP;
                end
            end
            WS_RESP: begin
                if (m_bvalid) begin
                    ring_adv = 1'b1;
                    ctl_d.st = WS_IDLE;
                end
            end
            default: ctl_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= WS_IDLE;
            ctl_q.beat   <= '0;
            ctl_q.awaddr <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign m_awaddr  = ctl_q.awaddr;
    assign m_awlen   = 8'(BEATS - 1);
    assign m_awsize  = 3'(SIZE_LG);
    assign m_awburst = AXI_BURST_INCR;
    assign m_awvalid = (ctl_q.st == WS_ADDR);
    assign m_wdata   = fifo_dout;
    assign m_wstrb   = '1;
    assign m_wvalid  = (ctl_q.st == WS_DATA);
    assign m_wlast   = m_wvalid && (ctl_q.beat == LAST_BEAT);
    assign m_bready  = (ctl_q.st == WS_RESP);

    AST_AW_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> ($past(fifo_level) >= BURST_FILL));  // R1

    AST_W_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> !fifo_empty);  // R2

    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wready && m_wlast |=> !m_wvalid);  // R2

    AST_CNT_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_bvalid && m_bready) |=> $stable(burst_cnt));  // R4

    AST_RESP_BLOCKS_AW: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready && !m_bvalid |=> m_bready && !m_awvalid);  // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid && s_tready |-> (fifo_level < DEPTH_C));  // R7

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));  // R9

endmodule

// File: tb/test_stream_burst_writer.sv
module test_stream_burst_writer;

    localparam int DW    = 64;
    localparam int AWD   = 32;
    localparam int CW    = 4;
    localparam int FAW   = 5;
    localparam int BEATS = 16;
    localparam int DEPTH = 1 << FAW;
    localparam int LOGSZ = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AWD-1:0]  base_addr;
    logic [CW-1:0]   wrap_bursts;
    logic [CW-1:0]   burst_cnt;
    logic [DW-1:0]   s_tdata;
    logic            s_tvalid;
    logic            s_tready;
    logic [AWD-1:0]  m_awaddr;
    logic [7:0]      m_awlen;
    logic [2:0]      m_awsize;
    logic [1:0]      m_awburst;
    logic            m_awvalid;
    logic            m_awready;
    logic [DW-1:0]   m_wdata;
    logic [DW/8-1:0] m_wstrb;
    logic            m_wlast;
    logic            m_wvalid;
    logic            m_wready;
    logic            m_bvalid;
    logic            m_bready;

    stream_burst_writer #(
        .DATA_W  (DW),
        .ADDR_W  (AWD),
        .CNT_W   (CW),
        .FIFO_AW (FAW),
        .BEATS   (BEATS)
    ) i_stream_burst_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_addr   (base_addr),
        .wrap_bursts (wrap_bursts),
        .burst_cnt   (burst_cnt),
        .s_tdata     (s_tdata),
        .s_tvalid    (s_tvalid),
        .s_tready    (s_tready),
        .m_awaddr    (m_awaddr),
        .m_awlen     (m_awlen),
        .m_awsize    (m_awsize),
        .m_awburst   (m_awburst),
        .m_awvalid   (m_awvalid),
        .m_awready   (m_awready),
        .m_wdata     (m_wdata),
        .m_wstrb     (m_wstrb),
        .m_wlast     (m_wlast),
        .m_wvalid    (m_wvalid),
        .m_wready    (m_wready),
        .m_bvalid    (m_bvalid),
        .m_bready    (m_bready)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AWD-1:0] exp_addr(input logic [AWD-1:0] b, input logic [CW-1:0] c);
        return b + (AWD'(c) << 7);
    endfunction

    function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c, input logic [CW-1:0] w);
        return (c == w) ? '0 : c + 1'b1;
    endfunction

    // Reference model state, updated only in the monitor below.
    logic [DW-1:0] sent [LOGSZ];
    int        pushed = 0, popped = 0, pushed_prev = 0, beat_i = 0;
    logic [CW-1:0]  exp_cnt = '0;
    logic [AWD-1:0] aw_hold = '0;
    bit        inflight = 0, aw_wait = 0, aw_done = 0, tv_acc = 0;
    bit        b_pend = 0, saw_full = 0;
    int        b_delay = 0;
    int        p_tv = 0, p_aw = 100, p_w = 100;

    // Monitor and slave model: sample at negedge, drive inputs for next posedge.
    initial begin
        s_tvalid  = 1'b0;
        s_tdata   = '0;
        m_awready = 1'b0;
        m_wready  = 1'b0;
        m_bvalid  = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                popped      = pushed;
                pushed_prev = pushed;
                exp_cnt     = '0;
                inflight    = 0;
                aw_wait     = 0;
                aw_done     = 0;
                beat_i      = 0;
                b_pend      = 0;
                tv_acc      = 0;
                s_tvalid    = 1'b0;
                m_awready   = 1'b0;
                m_wready    = 1'b0;
                m_bvalid    = 1'b0;
            end else begin : mon_step
                int lag;
                lag         = pushed_prev;
                pushed_prev = pushed;

                chk(burst_cnt == exp_cnt, "R4 burst counter", 64'(burst_cnt), 64'(exp_cnt));
                chk(s_tready == ((pushed - popped) < DEPTH), "R7 ready vs fill",
                    64'(s_tready), 64'((pushed - popped) < DEPTH));
                if (!s_tready) saw_full = 1;

                if (m_awvalid && !aw_wait) begin
                    chk(!inflight, "R6 address while response pending", 64'(inflight), 64'd0);
                    chk((lag - popped) >= BEATS, "R1 fill at launch", 64'(lag - popped), 64'(BEATS));
                    chk(m_awaddr == exp_addr(base_addr, exp_cnt), "R5 burst address",
                        64'(m_awaddr), 64'(exp_addr(base_addr, exp_cnt)));
                    chk(m_awlen == 8'd15, "R3 length code", 64'(m_awlen), 64'd15);
                    chk(m_awsize == 3'd3, "R3 size code", 64'(m_awsize), 64'd3);
                    chk(m_awburst == 2'b01, "R3 burst type", 64'(m_awburst), 64'd1);
                    inflight = 1;
                    aw_hold  = m_awaddr;
                end else if (m_awvalid && aw_wait) begin
                    chk(m_awaddr == aw_hold, "R9 address held", 64'(m_awaddr), 64'(aw_hold));
                end
                if (m_wvalid)
                    chk(aw_done, "R6 data before address", 64'(aw_done), 64'd1);

                // New inputs for the coming edge.
                m_awready = ($urandom % 100) < p_aw;
                m_wready  = ($urandom % 100) < p_w;
                if (b_pend) begin
                    if (b_delay == 0) m_bvalid = 1'b1;
                    else              b_delay--;
                end else begin
                    m_bvalid = 1'b0;
                end
                if (!s_tvalid || tv_acc) begin
                    s_tvalid = ($urandom % 100) < p_tv;
                    if (s_tvalid) s_tdata = {$urandom, $urandom};
                end

                // Handshakes that fire at the coming edge.
                tv_acc = s_tvalid && s_tready;
                if (tv_acc) begin
                    sent[pushed % LOGSZ] = s_tdata;
                    pushed++;
                end
                if (m_awvalid) begin
                    aw_wait = !m_awready;
                    if (m_awready) aw_done = 1;
                end
                if (m_wvalid && m_wready) begin
                    chk(m_wdata == sent[popped % LOGSZ], "R2 data order", m_wdata, sent[popped % LOGSZ]);
                    chk(m_wstrb == '1, "R2 strobes", 64'(m_wstrb), 64'hff);
                    chk(m_wlast == (beat_i == BEATS - 1), "R2 last beat",
                        64'(m_wlast), 64'(beat_i == BEATS - 1));
                    popped++;
                    beat_i++;
                    if (beat_i == BEATS) begin
                        beat_i  = 0;
                        b_pend  = 1;
                        b_delay = $urandom % 4;
                    end
                end
                if (m_bvalid && m_bready) begin
                    exp_cnt  = next_cnt(exp_cnt, wrap_bursts);
                    inflight = 0;
                    aw_done  = 0;
                    b_pend   = 0;
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic quiesce();
        p_tv = 0;
        p_aw = 100;
        p_w  = 100;
        do cycles(1); while (inflight || s_tvalid || (pushed - popped) >= BEATS || m_awvalid);
        cycles(5);
    endtask

    task automatic run_random(input int n);
        p_tv = 70;
        p_aw = 60;
        p_w  = 70;
        cycles(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        base_addr   = 32'h1000_0000;
        wrap_bursts = 4'd3;

        // R8: reset state
        cycles(3);
        chk(m_awvalid == 1'b0, "R8 awvalid in reset", 64'(m_awvalid), 64'd0);
        chk(m_wvalid == 1'b0, "R8 wvalid in reset", 64'(m_wvalid), 64'd0);
        chk(m_bready == 1'b0, "R8 bready in reset", 64'(m_bready), 64'd0);
        chk(burst_cnt == '0, "R8 counter in reset", 64'(burst_cnt), 64'd0);
        chk(s_tready == 1'b1, "R8 ready in reset", 64'(s_tready), 64'd1);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: ten samples never start a burst
        p_tv = 100;
        while (pushed < 10) @(posedge clk);
        p_tv = 0;
        cycles(30);
        chk(m_awvalid == 1'b0 && !inflight, "R1 below threshold", 64'(m_awvalid), 64'd0);
        chk(burst_cnt == '0, "R1 counter idle", 64'(burst_cnt), 64'd0);

        // Random traffic with wrap at slot 3
        run_random(1500);
        quiesce();

        // R7: stall address channel until FIFO fills
        saw_full = 0;
        p_aw = 0;
        p_tv = 100;
        cycles(120);
        chk(s_tready == 1'b0, "R7 full drops ready", 64'(s_tready), 64'd0);
        chk(saw_full, "R7 full observed", 64'(saw_full), 64'd1);
        run_random(400);
        quiesce();

        // R4 R5: new base, wrap value 0
        base_addr   = 32'h2000_0400;
        wrap_bursts = 4'd0;
        run_random(600);
        quiesce();
        chk(burst_cnt == '0, "R4 wrap at zero", 64'(burst_cnt), 64'd0);

        // R4: lower the wrap value below the running count
        wrap_bursts = 4'd9;
        run_random(900);
        quiesce();
        wrap_bursts = 4'd1;
        base_addr   = 32'hffff_fc00;
        run_random(1200);
        quiesce();

        // R8: reset with samples left in the FIFO
        begin : leftover
            int target;
            target = pushed + 7;
            p_tv = 100;
            while (pushed < target) @(posedge clk);
            p_tv = 0;
        end
        cycles(4);
        @(posedge clk); #1 rst_n = 1'b0;
        cycles(3);
        @(posedge clk); #1 rst_n = 1'b1;
        cycles(1);
        chk(burst_cnt == '0, "R8 counter cleared", 64'(burst_cnt), 64'd0);
        chk(s_tready == 1'b1, "R8 ready after reset", 64'(s_tready), 64'd1);
        base_addr   = 32'h3000_0000;
        wrap_bursts = 4'd5;
        begin : fresh
            int target;
            target = pushed + BEATS;
            p_tv = 100;
            while (pushed < target) @(posedge clk);
            p_tv = 0;
        end
        quiesce();
        chk(burst_cnt == 4'd1, "R8 first burst after reset", 64'(burst_cnt), 64'd1);
        chk(pushed == popped, "R8 old samples discarded", 64'(pushed - popped), 64'd0);

        summary();
        $finish;
    end

endmodule